// File: doc/BRIEF.md
# Mailbox Temporary Disable Handshake

This block lets software rewrite the payload of a transmit mailbox that is live and serving automatic replies to remote frames, without losing a remote request that arrives meanwhile and without letting a half-written payload go onto the bus. Software names one mailbox through a control write that carries a mailbox index and a request bit. The block waits until that mailbox has no transmission in flight and then raises a grant flag. While the grant is up, payload writes to that one mailbox are let through, the mailbox is withheld from transmit arbitration, and remote requests aimed at it are parked.

When software drops the request bit, the grant falls one clock later. The cycle after that, any parked remote request is released as a single transmit trigger, so the reply carries the fresh payload. Mailbox storage and the protocol engine sit outside. Each mailbox reports a busy level and a remote-request pulse. The block returns a payload-write verdict, an arbitration exclusion vector and a per-mailbox transmit trigger.

Top module: `mbx_tdis`

## Requirements
- R1: After reset, td_req, td_ack, td_ptr, arb_excl and tx_trig are all zero.
- R2: A control write (ctl_wr high for one clock) made while td_ack is low loads ctl_ptr into td_ptr and ctl_req into td_req, both visible after that clock edge.
- R3: With td_req high, td_ack rises one clock edge after a cycle in which mbx_busy[td_ptr] is low. While that bit stays high, td_ack stays low and the request waits.
- R4: A rrq_in pulse for a mailbox that is not excluded gives a one-cycle tx_trig pulse on that mailbox one clock later. A pulse for the excluded mailbox gives no trigger while it is excluded. It is latched and released as a tx_trig pulse one clock after td_ack falls.
- R5: A control write with ctl_req low made while td_ack is high clears td_req at that edge, and td_ack falls at the following edge. Control writes made in the cycle where td_req is low and td_ack is still high are ignored.
- R6: While td_ack is high, the ctl_ptr field of control writes is ignored and td_ptr holds. arb_excl is the one-hot of td_ptr while td_ack is high, and zero otherwise.
- R7: dwr_ok is high in the same cycle as dwr_valid when mailbox dwr_mbx has mbx_tx_en low. It is also high when td_ack is high and dwr_mbx equals td_ptr. For any other mailbox with mbx_tx_en high it is low.
- R8: Any number of rrq_in pulses for the excluded mailbox during one grant give exactly one tx_trig pulse after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_ptr | input | 5 | Mailbox index carried by the control write |
| ctl_req | input | 1 | Request bit carried by the control write |
| mbx_tx_en | input | 32 | Per mailbox: enabled and configured to transmit |
| mbx_busy | input | 32 | Per mailbox: transmission in progress |
| rrq_in | input | 32 | Per mailbox: remote request received (pulse) |
| dwr_valid | input | 1 | Payload write attempt |
| dwr_mbx | input | 5 | Mailbox targeted by the payload write |
| dwr_ok | output | 1 | Payload write accepted |
| td_req | output | 1 | Request bit as held by the block |
| td_ack | output | 1 | Grant flag |
| td_ptr | output | 5 | Mailbox index as held by the block |
| arb_excl | output | 32 | Mailboxes withheld from transmit arbitration |
| tx_trig | output | 32 | Per mailbox transmit trigger for a remote reply |

## Verification
The properties assume that rrq_in and mbx_busy are plain per-mailbox levels or pulses with no relation to the control path. They also assume that ctl_wr is a single-cycle strobe whose fields are stable in that cycle. The stimulus changes every input only on the falling clock edge, holds each remote-request pulse for exactly one cycle, and keeps the selected mailbox's busy bit high across the request write when it tests the waiting case. Since no arbitration engine is present, the busy bit is driven freely and never depends on tx_trig.

// File: rtl/td_pkg.sv
package td_pkg;
  typedef enum logic [1:0] {
    TD_IDLE  = 2'd0,
    TD_WAIT  = 2'd1,
    TD_GRANT = 2'd2,
    TD_DRAIN = 2'd3
  } td_state_e;
endpackage

// File: rtl/td_ctrl.sv
module td_ctrl
  import td_pkg::*;
#(
  parameter int NMBX  = 32,
  parameter int PTR_W = $clog2(NMBX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [PTR_W-1:0] ctl_ptr,
  input  logic             ctl_req,
  input  logic [NMBX-1:0]  mbx_busy,
  output logic             req_o,
  output logic             ack_o,
  output logic [PTR_W-1:0] ptr_o
);
  td_state_e        st_q, st_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             ptr_en;
  logic             sel_busy;

  assign sel_busy = mbx_busy[ptr_q];

  always_comb begin
    st_d   = st_q;
    ptr_d  = ctl_ptr;
    ptr_en = 1'b0;
    unique case (st_q)
      TD_IDLE: begin
        if (ctl_wr) begin
          ptr_en = 1'b1;
          if (ctl_req) st_d = TD_WAIT;
        end
      end
      TD_WAIT: begin
        if (ctl_wr) begin
          ptr_en = 1'b1;
          st_d   = ctl_req ? TD_WAIT : TD_IDLE;
        end else if (!sel_busy) begin
          st_d = TD_GRANT;
        end
      end
      TD_GRANT: begin
        if (ctl_wr && !ctl_req) st_d = TD_DRAIN;
      end
      TD_DRAIN: st_d = TD_IDLE;
      default:  st_d = TD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= TD_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign req_o = (st_q == TD_WAIT) || (st_q == TD_GRANT);
  assign ack_o = (st_q == TD_GRANT) || (st_q == TD_DRAIN);
  assign ptr_o = ptr_q;
endmodule

// File: rtl/td_wr_gate.sv
module td_wr_gate #(
  parameter int NMBX  = 32,
  parameter int PTR_W = $clog2(NMBX)
) (
  input  logic             dwr_valid,
  input  logic [PTR_W-1:0] dwr_mbx,
  input  logic [NMBX-1:0]  mbx_tx_en,
  input  logic [NMBX-1:0]  hold,
  output logic             dwr_ok
);
  logic live_tx;
  logic unlocked;

  assign live_tx  = mbx_tx_en[dwr_mbx];
  assign unlocked = hold[dwr_mbx];
  assign dwr_ok   = dwr_valid && (!live_tx || unlocked);
endmodule

// File: rtl/td_rrq_slice.sv
module td_rrq_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic rrq,
  output logic trig
);
  logic pend_q, pend_d;
  logic trig_q, trig_d;

  always_comb begin
    pend_d = hold && (pend_q || rrq);
    trig_d = !hold && (pend_q || rrq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      trig_q <= trig_d;
    end
  end

  assign trig = trig_q;
endmodule

// File: rtl/mbx_tdis.sv
module mbx_tdis #(
  parameter int NMBX  = 32,
  parameter int PTR_W = $clog2(NMBX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [PTR_W-1:0] ctl_ptr,
  input  logic             ctl_req,
  input  logic [NMBX-1:0]  mbx_tx_en,
  input  logic [NMBX-1:0]  mbx_busy,
  input  logic [NMBX-1:0]  rrq_in,
  input  logic             dwr_valid,
  input  logic [PTR_W-1:0] dwr_mbx,
  output logic             dwr_ok,
  output logic             td_req,
  output logic             td_ack,
  output logic [PTR_W-1:0] td_ptr,
  output logic [NMBX-1:0]  arb_excl,
  output logic [NMBX-1:0]  tx_trig
);
  logic [NMBX-1:0] hold;

  td_ctrl #(.NMBX(NMBX), .PTR_W(PTR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .ctl_ptr  (ctl_ptr),
    .ctl_req  (ctl_req),
    .mbx_busy (mbx_busy),
    .req_o    (td_req),
    .ack_o    (td_ack),
    .ptr_o    (td_ptr)
  );

  for (genvar i = 0; i < NMBX; i++) begin : g_mbx
    assign hold[i] = td_ack && (td_ptr == PTR_W'(i));
    td_rrq_slice u_slice (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold[i]),
      .rrq   (rrq_in[i]),
      .trig  (tx_trig[i])
    );
  end

  td_wr_gate #(.NMBX(NMBX), .PTR_W(PTR_W)) u_gate (
    .dwr_valid (dwr_valid),
    .dwr_mbx   (dwr_mbx),
    .mbx_tx_en (mbx_tx_en),
    .hold      (hold),
    .dwr_ok    (dwr_ok)
  );

  assign arb_excl = hold;
endmodule

// File: rtl/mbx_tdis_chk.sv
module mbx_tdis_chk #(
  parameter int NMBX  = 32,
  parameter int PTR_W = $clog2(NMBX)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic [PTR_W-1:0] ctl_ptr,
  input logic             ctl_req,
  input logic [NMBX-1:0]  mbx_tx_en,
  input logic [NMBX-1:0]  mbx_busy,
  input logic             dwr_valid,
  input logic [PTR_W-1:0] dwr_mbx,
  input logic             dwr_ok,
  input logic             td_req,
  input logic             td_ack,
  input logic [PTR_W-1:0] td_ptr,
  input logic [NMBX-1:0]  arb_excl,
  input logic [NMBX-1:0]  tx_trig
);
  logic sel_busy;
  logic foreign_live;
  assign sel_busy     = mbx_busy[td_ptr];
  assign foreign_live = dwr_valid && mbx_tx_en[dwr_mbx] && !(td_ack && dwr_mbx == td_ptr);

  AST_ACK_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(td_ack) |-> $past(td_req && !sel_busy));                       // R3
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (td_ack && !td_req) |=> !td_ack);                                    // R5
  AST_PTR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (td_ack && $past(td_ack)) |-> td_ptr == $past(td_ptr));              // R6
  AST_EXCL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(arb_excl) && (td_ack || arb_excl == '0));                   // R6
  AST_FOREIGN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    foreign_live |-> !dwr_ok);                                           // R7
  AST_NO_TRIG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_trig & $past(arb_excl)) == '0);                                  // R4
endmodule

bind mbx_tdis mbx_tdis_chk #(.NMBX(NMBX), .PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_wr    (ctl_wr),
  .ctl_ptr   (ctl_ptr),
  .ctl_req   (ctl_req),
  .mbx_tx_en (mbx_tx_en),
  .mbx_busy  (mbx_busy),
  .dwr_valid (dwr_valid),
  .dwr_mbx   (dwr_mbx),
  .dwr_ok    (dwr_ok),
  .td_req    (td_req),
  .td_ack    (td_ack),
  .td_ptr    (td_ptr),
  .arb_excl  (arb_excl),
  .tx_trig   (tx_trig)
);

// File: tb/sim_mbx_tdis.sv
`timescale 1ns/1ps
module sim_mbx_tdis;
  localparam int N = 32;
  localparam int W = 5;

  logic         clk;
  logic         rst_n;
  logic         ctl_wr;
  logic [W-1:0] ctl_ptr;
  logic         ctl_req;
  logic [N-1:0] mbx_tx_en;
  logic [N-1:0] mbx_busy;
  logic [N-1:0] rrq_in;
  logic         dwr_valid;
  logic [W-1:0] dwr_mbx;
  logic         dwr_ok;
  logic         td_req;
  logic         td_ack;
  logic [W-1:0] td_ptr;
  logic [N-1:0] arb_excl;
  logic [N-1:0] tx_trig;

  int n_chk = 0;
  int n_err = 0;

  mbx_tdis u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_ptr(ctl_ptr),
    .ctl_req(ctl_req), .mbx_tx_en(mbx_tx_en), .mbx_busy(mbx_busy),
    .rrq_in(rrq_in), .dwr_valid(dwr_valid), .dwr_mbx(dwr_mbx),
    .dwr_ok(dwr_ok), .td_req(td_req), .td_ack(td_ack), .td_ptr(td_ptr),
    .arb_excl(arb_excl), .tx_trig(tx_trig)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [W-1:0] p, input logic r);
    ctl_wr = 1'b1; ctl_ptr = p; ctl_req = r;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 req", td_req, 0);
    check("R1 ack", td_ack, 0);
    check("R1 ptr", td_ptr, 0);
    check("R1 excl", arb_excl, 0);
    check("R1 trig", tx_trig, 0);
  endtask

  task automatic t_grant();
    mbx_busy[3] = 1'b1;
    ctl(5'd3, 1'b1);
    check("R2 req", td_req, 1);
    check("R2 ptr", td_ptr, 3);
    repeat (3) @(negedge clk);
    check("R3 wait while busy", td_ack, 0);
    mbx_busy[3] = 1'b0;
    @(negedge clk);
    check("R3 ack after idle", td_ack, 1);
    check("R6 excl onehot", arb_excl, 64'h8);
  endtask

  task automatic t_ptr_lock();
    ctl(5'd7, 1'b1);
    check("R6 ptr held", td_ptr, 3);
    check("R6 ack held", td_ack, 1);
  endtask

  task automatic t_write();
    dwr_valid = 1'b1;
    dwr_mbx = 5'd3; #1;
    check("R7 granted mailbox", dwr_ok, 1);
    dwr_mbx = 5'd5; #1;
    check("R7 other live mailbox", dwr_ok, 0);
    dwr_mbx = 5'd9; #1;
    check("R7 non-transmit mailbox", dwr_ok, 1);
    dwr_valid = 1'b0; #1;
    check("R7 no write", dwr_ok, 0);
  endtask

  task automatic t_rrq();
    rrq_in[3] = 1'b1; rrq_in[5] = 1'b1;
    @(negedge clk);
    rrq_in = '0;
    check("R4 unheld trigger", tx_trig[5], 1);
    check("R4 held no trigger", tx_trig[3], 0);
    @(negedge clk);
    check("R4 unheld single pulse", tx_trig[5], 0);
    rrq_in[3] = 1'b1;
    @(negedge clk);
    rrq_in = '0;
    check("R8 held no trigger", tx_trig[3], 0);
    ctl(5'd3, 1'b0);
    check("R5 req cleared", td_req, 0);
    check("R5 ack still up", td_ack, 1);
    @(negedge clk);
    check("R5 ack dropped", td_ack, 0);
    check("R6 excl cleared", arb_excl, 0);
    check("R4 no trigger yet", tx_trig[3], 0);
    @(negedge clk);
    check("R4 released trigger", tx_trig[3], 1);
    @(negedge clk);
    check("R8 single release pulse", tx_trig[3], 0);
    @(negedge clk);
    check("R8 no further pulse", tx_trig, 0);
  endtask

  task automatic t_repoint();
    ctl(5'd12, 1'b0);
    check("R2 ptr reload", td_ptr, 12);
    check("R2 req low", td_req, 0);
  endtask

  initial begin
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_ptr = '0; ctl_req = 1'b0;
    mbx_tx_en = '0; mbx_tx_en[3] = 1'b1; mbx_tx_en[5] = 1'b1;
    mbx_busy = '0; rrq_in = '0; dwr_valid = 1'b0; dwr_mbx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_grant();
        t_ptr_lock();
        t_write();
        t_rrq();
        t_repoint();
      end
      begin
        repeat (10000) @(negedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule